// File: doc/BRIEF.md
# UART Data and Receive-Status Register Front End

This block sits between a simple bus slave port and a UART character transmitter and receiver. Software sees two byte-wide words. The data word queues transmit bytes when written and hands out received bytes when read. The status word reports the error flags of the last character read. Any write to the status word clears those flags.

Each direction has a queue of parameterised depth. When `fifo_en` is low, each queue holds one entry and acts as a holding register. The receiver core delivers a byte together with its framing flag, break flag and received parity bit. This block computes the parity error from the parity enable and parity sense inputs, and it detects overrun itself.

The error flags of a character are stored next to its data byte. They reach the status word only when that byte is read. Software therefore reads data first and status second.

Top module: `uart_regfront`

## Requirements
- R1: With `fifo_en` high, a bus write to offset 0x00 appends `bus_wdata` to a transmit queue of `DEPTH` entries. `tx_valid` is high and `tx_data` shows the oldest byte while the queue is not empty. A cycle with `tx_ready` high removes that byte, and bytes leave in the order written.
- R2: A write to offset 0x00 while `tx_full` is high is discarded, and the queued bytes are unchanged.
- R3: A bus read of offset 0x00 returns the oldest received byte on `bus_rdata` in the same cycle and removes it at the clock edge. Bytes leave in arrival order.
- R4: Reading offset 0x04 gives the status word: bit 0 framing error, bit 1 parity error, bit 2 break, bit 3 overrun, bits 7..4 zero. Its reset value is 0x00.
- R5: Status bits 2..0 are loaded from the flags of the character removed by a data read, replacing their old values. Characters that arrive without being read leave these bits unchanged.
- R6: The parity error of a character is set when `par_en` is high and the XOR of its 8 data bits and `rx_par_bit` differs from `par_odd`. `par_odd` = 0 selects even parity and 1 selects odd parity. The flag is sampled when the character arrives.
- R7: A character offered while `rx_full` is high is dropped, and the queue contents are kept. Status bit 3 is set at that edge, and it stays set through data reads until a clear.
- R8: Any write to offset 0x04 clears status bits 3..0, whatever the data value.
- R9: A read of offset 0x00 while `rx_empty` is high returns 0x00 and leaves the status word unchanged.
- R10: With `fifo_en` low, each direction holds one entry, so its full flag rises after one byte.
- R11: `rx_full`, `rx_empty`, `tx_full` and `tx_empty` track occupancy. After reset both queues are empty and neither is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: queues of DEPTH entries, 0: single holding entry |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, valid in the cycle of `bus_rd` |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_ready | input | 1 | Transmitter takes `tx_data` |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_valid | input | 1 | Receiver offers a character |
| rx_data | input | 8 | Received byte |
| rx_par_bit | input | 1 | Received parity bit |
| rx_frame_err | input | 1 | Stop bit was invalid |
| rx_break | input | 1 | Break detected on the line |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |

## Verification
The bench reads the status word before and after each data read. A design that loaded flags on arrival would show a character's error before that character was read. The bench overfills the receive queue with an extra character that carries a framing error. A design that overwrote an entry or kept the extra byte would break the read-back order or show the framing bit, and one that did not latch overrun would drop bit 3 during the later reads. Empty reads check for a zero byte and an untouched status word. Single-entry mode must report full after one byte in each direction and drop the second.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
   localparam int BYTE_W = 8;

   // one receive queue entry: byte plus its per-character flags
   typedef struct packed {
      logic              brk;
      logic              perr;
      logic              ferr;
      logic [BYTE_W-1:0] data;
   } rx_entry_t;

   localparam int ENTRY_W = $bits(rx_entry_t);

   // word offsets seen by the bus
   localparam int OFF_DATA = 0;
   localparam int OFF_STAT = 4;

   // status word bit positions
   localparam int ST_FE = 0;
   localparam int ST_PE = 1;
   localparam int ST_BE = 2;
   localparam int ST_OE = 3;
endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             single,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_rf_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("uart_rf_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = single ? (count != '0) : (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   // pointer advance: natural wrap for power-of-two depths, compare otherwise
   if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_rf_rx.sv
module uart_rf_rx
   import uart_rf_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_par_bit,
   input  logic              rx_frame_err,
   input  logic              rx_break,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              rd_pop,
   input  logic              stat_clr,
   output logic [BYTE_W-1:0] rd_byte,
   output logic [BYTE_W-1:0] status,
   output logic              full,
   output logic              empty
);
   rx_entry_t in_ent, head_ent;
   logic      ovr_set, take;
   logic      fe_q, pe_q, be_q, oe_q;

   // parity check at arrival: ones count of data plus parity bit against sense
   assign in_ent.data = rx_data;
   assign in_ent.ferr = rx_frame_err;
   assign in_ent.brk  = rx_break;
   assign in_ent.perr = par_en && ((^{rx_data, rx_par_bit}) != par_odd);

   assign ovr_set = rx_valid && full;
   assign take    = rd_pop && !empty;

   uart_rf_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .single(!fifo_en),
      .push  (rx_valid),
      .pop   (take),
      .wdata (in_ent),
      .rdata (head_ent),
      .full  (full),
      .empty (empty)
   );

   assign rd_byte = empty ? '0 : head_ent.data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fe_q <= 1'b0;
         pe_q <= 1'b0;
         be_q <= 1'b0;
         oe_q <= 1'b0;
      end else if (stat_clr) begin
         fe_q <= 1'b0;
         pe_q <= 1'b0;
         be_q <= 1'b0;
         oe_q <= ovr_set;
      end else begin
         if (take) begin
            fe_q <= head_ent.ferr;
            pe_q <= head_ent.perr;
            be_q <= head_ent.brk;
         end
         if (ovr_set) oe_q <= 1'b1;
      end
   end

   always_comb begin
      status        = '0;
      status[ST_FE] = fe_q;
      status[ST_PE] = pe_q;
      status[ST_BE] = be_q;
      status[ST_OE] = oe_q;
   end
endmodule

// File: rtl/uart_rf_tx.sv
module uart_rf_tx
   import uart_rf_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              wr_push,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              tx_ready,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   output logic              full,
   output logic              empty
);
   logic [BYTE_W-1:0] head;

   uart_rf_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .single(!fifo_en),
      .push  (wr_push),
      .pop   (tx_ready),
      .wdata (wr_byte),
      .rdata (head),
      .full  (full),
      .empty (empty)
   );

   assign tx_valid = !empty;
   assign tx_data  = empty ? '0 : head;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_rf_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_full,
   output logic              tx_empty,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_par_bit,
   input  logic              rx_frame_err,
   input  logic              rx_break,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              rx_full,
   output logic              rx_empty
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("uart_regfront: ADDR_W must reach offset 4");
   end

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

   logic              hit_data, hit_stat;
   logic [BYTE_W-1:0] rx_byte, rx_status;

   assign hit_data = (bus_addr == A_DATA);
   assign hit_stat = (bus_addr == A_STAT);

   uart_rf_tx #(.DEPTH(DEPTH)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .fifo_en (fifo_en),
      .wr_push (bus_wr && hit_data),
      .wr_byte (bus_wdata),
      .tx_ready(tx_ready),
      .tx_data (tx_data),
      .tx_valid(tx_valid),
      .full    (tx_full),
      .empty   (tx_empty)
   );

   uart_rf_rx #(.DEPTH(DEPTH)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .fifo_en     (fifo_en),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .rx_par_bit  (rx_par_bit),
      .rx_frame_err(rx_frame_err),
      .rx_break    (rx_break),
      .par_en      (par_en),
      .par_odd     (par_odd),
      .rd_pop      (bus_rd && hit_data),
      .stat_clr    (bus_wr && hit_stat),
      .rd_byte     (rx_byte),
      .status      (rx_status),
      .full        (rx_full),
      .empty       (rx_empty)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (hit_data)      bus_rdata = rx_byte;
         else if (hit_stat) bus_rdata = rx_status;
      end
   end
endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_rdata,
   input logic              rx_valid,
   input logic              rx_full,
   input logic              rx_empty,
   input logic              tx_full,
   input logic              tx_empty,
   input logic              tx_ready,
   input logic [7:0]        stat
);
   localparam logic [ADDR_W-1:0] A_DATA = '0;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);

   // R4
   stat_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == A_STAT |-> bus_rdata[7:4] == 4'h0);

   // R7
   overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_full |=> stat[3]);

   // R8
   clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_STAT && !(rx_valid && rx_full) |=> stat[3:0] == 4'h0);

   // R9
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == A_DATA && rx_empty |-> bus_rdata == 8'h00);

   // R9
   empty_read_keeps_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == A_DATA && rx_empty && !(rx_valid && rx_full) |=> $stable(stat));

   // R11
   rx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_full && rx_empty));

   // R2
   tx_full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full && !tx_ready |=> tx_full);

   // R11
   tx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty));
endmodule

bind uart_regfront uart_rf_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .rx_valid (rx_valid),
   .rx_full  (rx_full),
   .rx_empty (rx_empty),
   .tx_full  (tx_full),
   .tx_empty (tx_empty),
   .tx_ready (tx_ready),
   .stat     (rx_status)
);

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
   localparam int DEPTH = 16;
   localparam int AW    = 3;

   logic clk = 0, rst_n = 0, fifo_en = 1;
   logic bus_wr = 0, bus_rd = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata, tx_data, rx_data = '0;
   logic tx_valid, tx_ready = 0, tx_full, tx_empty;
   logic rx_valid = 0, rx_par_bit = 0, rx_frame_err = 0, rx_break = 0;
   logic par_en = 0, par_odd = 0, rx_full, rx_empty;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   uart_regfront #(.DEPTH(DEPTH), .ADDR_W(AW)) u0 (.*);

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk); bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic rx_push(logic [7:0] d, logic pb, logic fe, logic brk);
      @(negedge clk); rx_valid = 1; rx_data = d; rx_par_bit = pb;
      rx_frame_err = fe; rx_break = brk;
      @(negedge clk); rx_valid = 0; rx_frame_err = 0; rx_break = 0;
   endtask

   task automatic tx_take(string req, logic [7:0] exp);
      @(negedge clk); #1;
      chk({req, " tx_valid"}, {7'd0, tx_valid}, 8'h01);
      chk({req, " tx_data"}, tx_data, exp);
      tx_ready = 1;
      @(negedge clk); tx_ready = 0;
   endtask

   task automatic read_pair(string req, logic [7:0] d_exp, logic [7:0] s_exp);
      logic [7:0] v;
      bus_read(3'd0, v); chk({req, " data"}, v, d_exp);
      bus_read(3'd4, v); chk({req, " status"}, v, s_exp);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      bus_read(3'd4, v);
      chk("R4 reset status", v, 8'h00);
      chk("R11 reset flags", {4'd0, rx_empty, rx_full, tx_empty, tx_full}, 8'h0A);
   endtask

   task automatic t_flag_order();
      logic [7:0] v;
      rx_push(8'hA5, 0, 0, 0);
      rx_push(8'h3C, 0, 1, 0);
      rx_push(8'h0F, 0, 0, 1);
      bus_read(3'd4, v);
      chk("R5 flags hidden before read", v, 8'h00);
      read_pair("R3 R5 first", 8'hA5, 8'h00);
      read_pair("R5 framing", 8'h3C, 8'h01);
      read_pair("R5 break", 8'h0F, 8'h04);
      chk("R11 rx empty after drain", {7'd0, rx_empty}, 8'h01);
   endtask

   task automatic t_parity();
      par_en = 1; par_odd = 0;
      rx_push(8'h03, 0, 0, 0);
      rx_push(8'h07, 0, 0, 0);
      par_odd = 1;
      rx_push(8'h07, 0, 0, 0);
      rx_push(8'h03, 0, 0, 0);
      par_en = 0;
      rx_push(8'h07, 0, 0, 0);
      read_pair("R6 even ok", 8'h03, 8'h00);
      read_pair("R6 even bad", 8'h07, 8'h02);
      read_pair("R6 odd ok", 8'h07, 8'h00);
      read_pair("R6 odd bad", 8'h03, 8'h02);
      read_pair("R6 disabled", 8'h07, 8'h00);
   endtask

   task automatic t_empty_clear();
      logic [7:0] v;
      rx_push(8'h5A, 0, 1, 1);
      read_pair("R5 two flags", 8'h5A, 8'h05);
      read_pair("R9 empty read", 8'h00, 8'h05);
      bus_write(3'd4, 8'h00);
      bus_read(3'd4, v);
      chk("R8 clear with zero data", v, 8'h00);
   endtask

   task automatic t_overrun();
      logic [7:0] v;
      for (int i = 0; i < DEPTH; i++) rx_push(8'h40 + 8'(i), 0, 0, 0);
      chk("R11 rx full", {7'd0, rx_full}, 8'h01);
      rx_push(8'hEE, 0, 1, 0);
      bus_read(3'd4, v);
      chk("R7 overrun immediate", v, 8'h08);
      for (int i = 0; i < DEPTH; i++) begin
         bus_read(3'd0, v);
         chk("R7 R3 contents kept", v, 8'h40 + 8'(i));
      end
      bus_read(3'd4, v);
      chk("R7 overrun sticky, dropped flags absent", v, 8'h08);
      chk("R7 rx empty", {7'd0, rx_empty}, 8'h01);
      bus_write(3'd4, 8'h5F);
      bus_read(3'd4, v);
      chk("R8 clear overrun", v, 8'h00);
   endtask

   task automatic t_tx_fifo();
      for (int i = 0; i < DEPTH; i++) bus_write(3'd0, 8'h80 + 8'(i));
      chk("R11 tx full", {7'd0, tx_full}, 8'h01);
      bus_write(3'd0, 8'hFF);
      for (int i = 0; i < DEPTH; i++) tx_take("R1 R2 order", 8'h80 + 8'(i));
      @(negedge clk); #1;
      chk("R2 extra byte dropped", {6'd0, tx_empty, tx_valid}, 8'h02);
   endtask

   task automatic t_single();
      logic [7:0] v;
      fifo_en = 0;
      rx_push(8'h11, 0, 0, 0);
      chk("R10 rx full after one", {7'd0, rx_full}, 8'h01);
      rx_push(8'h22, 0, 0, 0);
      read_pair("R10 holding rx", 8'h11, 8'h08);
      bus_read(3'd0, v);
      chk("R10 second dropped", v, 8'h00);
      bus_write(3'd4, 8'h00);
      bus_write(3'd0, 8'h55);
      chk("R10 tx full after one", {7'd0, tx_full}, 8'h01);
      bus_write(3'd0, 8'h66);
      tx_take("R10 holding tx", 8'h55);
      @(negedge clk); #1;
      chk("R10 tx empty", {7'd0, tx_empty}, 8'h01);
      fifo_en = 1;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_flag_order();
      t_parity();
      t_empty_clear();
      t_overrun();
      t_tx_fifo();
      t_single();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule